// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

This block walks a list of fixed-size descriptors held in memory and turns each one into an (address, length) pair for a downstream consumer. A start pulse gives it the base address of the list. It then fetches each 8-byte entry as two 32-bit little-endian words through a simple memory port. That port has a request strobe, a response strobe and no more than one read in flight. The length word of an entry comes first and the buffer address word second. Bit 31 of the length word marks the final entry.

Each decoded pair is offered on a valid/ready handshake. The walk ends normally after the pair from the marked entry has been accepted. The walk also ends, with an error pulse, when a parameterised number of entries has been forwarded and none of them carried the mark. Entries with a zero length are forwarded like any other entry. Fetching the buffers and processing their data is the consumer's job.

Top module: `sgl_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `memReqValid`, `pairValid`, `done` and `errCap` are all low.
- R2: For entry i the walker reads the length word at `baseAddr + 8*i` and then the address word at `baseAddr + 8*i + 4`. Only one read is in flight at a time, and no read is issued while a pair is being offered.
- R3: `pairLen` carries bits 27:0 of the length word, and `pairLast` carries its bit 31. Bits 30:28 are ignored.
- R4: `pairAddr` carries bits 30:0 of the address word. Bit 31 is dropped.
- R5: While `pairValid` is high and `pairReady` is low, the pair values stay unchanged and `pairValid` stays high.
- R6: After a pair with `pairLast` set is accepted, no further reads are made. `done` is high for exactly one cycle, in the cycle after that acceptance.
- R7: If `MAX_ENTRIES` entries have been forwarded and none was marked last, the walk stops with no further reads. `errCap` is high for one cycle, in the cycle after the final acceptance.
- R8: When the entry at position `MAX_ENTRIES` is itself marked last, the walk ends with `done` and without `errCap`. The two outputs are never high together.
- R9: An entry whose length field is zero is still forwarded as a pair with `pairLen` = 0.
- R10: A `start` pulse while `busy` is high is ignored. The running walk keeps its original base address and entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk at `baseAddr` (ignored when busy) |
| baseAddr | input | ADDR_W | Byte address of descriptor 0 |
| busy | output | 1 | A walk is in progress |
| memReqValid | output | 1 | One-cycle word read request |
| memReqAddr | output | ADDR_W | Byte address of the requested word |
| memRspValid | input | 1 | Read data is valid this cycle |
| memRspData | input | 32 | Read data word |
| pairValid | output | 1 | A decoded pair is offered |
| pairReady | input | 1 | Consumer accepts the pair |
| pairAddr | output | 31 | Buffer address of the entry |
| pairLen | output | 28 | Transfer length of the entry |
| pairLast | output | 1 | Entry carries the final-entry mark |
| done | output | 1 | Pulse: walk ended at a marked entry |
| errCap | output | 1 | Pulse: entry cap reached without a mark |

## Verification
The terminator check and the entry cap check are both evaluated on the same acceptance when the marked entry is the last one the cap allows. That acceptance must end the walk with `done` alone. The bench provokes this case by building a full list of `MAX_ENTRIES` descriptors with the mark on the final one. It then builds the same list with no mark. For each case it counts `done` and `errCap` pulses, counts the pairs and reads issued, and records the pair count at the moment each pulse appears. Several cases apply backpressure from the consumer and vary the memory latency, so that the offered pair has to be held.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  localparam int WORD_W    = 32;
  localparam int LEN_W     = 28;
  localparam int BUF_ADR_W = 31;
  localparam int LAST_POS  = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_LEN,
    ST_WAIT_LEN,
    ST_REQ_ADR,
    ST_WAIT_ADR,
    ST_EMIT
  } walkState_e;

  typedef struct packed {
    logic loadBase;
    logic capLen;
    logic capAdr;
    logic stepIdx;
    logic selAdrWord;
  } dpStrobe_t;

endpackage

// File: rtl/sgl_dp.sv
module sgl_dp
  import sgl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpStrobe_t            strobe,
  input  logic [ADDR_W-1:0]    baseIn,
  input  logic [WORD_W-1:0]    rspData,
  output logic [ADDR_W-1:0]    reqAddr,
  output logic [LEN_W-1:0]     curLen,
  output logic [BUF_ADR_W-1:0] curAdr,
  output logic                 curLast,
  output logic                 atCap
);

  localparam int IDX_W       = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int ENTRY_SHIFT = 3;
  localparam int WORD_OFS    = 4;

  logic [ADDR_W-1:0]    baseReg;
  logic [IDX_W-1:0]     entryIdx;
  logic [LEN_W-1:0]     lenReg;
  logic                 lastReg;
  logic [BUF_ADR_W-1:0] adrReg;
  logic [ADDR_W-1:0]    entryOfs;
  logic [ADDR_W-1:0]    wordOfs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseReg  <= '0;
      entryIdx <= '0;
    end else if (strobe.loadBase) begin
      baseReg  <= baseIn;
      entryIdx <= '0;
    end else if (strobe.stepIdx) begin
      entryIdx <= entryIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg  <= '0;
      lastReg <= 1'b0;
    end else if (strobe.capLen) begin
      lenReg  <= rspData[LEN_W-1:0];
      lastReg <= rspData[LAST_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adrReg <= '0;
    end else if (strobe.capAdr) begin
      adrReg <= rspData[BUF_ADR_W-1:0];
    end
  end

  always_comb begin
    entryOfs = ADDR_W'(entryIdx) << ENTRY_SHIFT;
    wordOfs  = strobe.selAdrWord ? ADDR_W'(WORD_OFS) : '0;
    reqAddr  = baseReg + entryOfs + wordOfs;
  end

  assign curLen  = lenReg;
  assign curAdr  = adrReg;
  assign curLast = lastReg;
  assign atCap   = (entryIdx == IDX_W'(MAX_ENTRIES - 1));

endmodule

// File: rtl/sgl_ctrl.sv
module sgl_ctrl
  import sgl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      rspValid,
  input  logic      pairReady,
  input  logic      curLast,
  input  logic      atCap,
  output dpStrobe_t strobe,
  output logic      memReqValid,
  output logic      pairValid,
  output logic      busy,
  output logic      done,
  output logic      errCap
);

  walkState_e state, stateNext;
  logic       accept;
  logic       doneNext;
  logic       errNext;

  assign accept = (state == ST_EMIT) && pairReady;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.loadBase = 1'b1;
          stateNext       = ST_REQ_LEN;
        end
      end
      ST_REQ_LEN: stateNext = ST_WAIT_LEN;
      ST_WAIT_LEN: begin
        if (rspValid) begin
          strobe.capLen = 1'b1;
          stateNext     = ST_REQ_ADR;
        end
      end
      ST_REQ_ADR: begin
        strobe.selAdrWord = 1'b1;
        stateNext         = ST_WAIT_ADR;
      end
      ST_WAIT_ADR: begin
        if (rspValid) begin
          strobe.capAdr = 1'b1;
          stateNext     = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (accept) begin
          if (curLast) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else if (atCap) begin
            errNext   = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.stepIdx = 1'b1;
            stateNext      = ST_REQ_LEN;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      errCap <= 1'b0;
    end else begin
      state  <= stateNext;
      done   <= doneNext;
      errCap <= errNext;
    end
  end

  assign memReqValid = (state == ST_REQ_LEN) || (state == ST_REQ_ADR);
  assign pairValid   = (state == ST_EMIT);
  assign busy        = (state != ST_IDLE);

endmodule

// File: rtl/sgl_walker.sv
module sgl_walker
  import sgl_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int MAX_ENTRIES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    baseAddr,
  output logic                 busy,
  output logic                 memReqValid,
  output logic [ADDR_W-1:0]    memReqAddr,
  input  logic                 memRspValid,
  input  logic [31:0]          memRspData,
  output logic                 pairValid,
  input  logic                 pairReady,
  output logic [30:0]          pairAddr,
  output logic [27:0]          pairLen,
  output logic                 pairLast,
  output logic                 done,
  output logic                 errCap
);

  dpStrobe_t strobe;
  logic      curLast;
  logic      atCap;

  sgl_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rspValid    (memRspValid),
    .pairReady   (pairReady),
    .curLast     (curLast),
    .atCap       (atCap),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .pairValid   (pairValid),
    .busy        (busy),
    .done        (done),
    .errCap      (errCap)
  );

  sgl_dp #(
    .ADDR_W      (ADDR_W),
    .MAX_ENTRIES (MAX_ENTRIES)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .baseIn  (baseAddr),
    .rspData (memRspData),
    .reqAddr (memReqAddr),
    .curLen  (pairLen),
    .curAdr  (pairAddr),
    .curLast (curLast),
    .atCap   (atCap)
  );

  assign pairLast = curLast;

endmodule

// File: rtl/sgl_walker_chk.sv
module sgl_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        memReqValid,
  input logic        memRspValid,
  input logic        pairValid,
  input logic        pairReady,
  input logic [30:0] pairAddr,
  input logic [27:0] pairLen,
  input logic        pairLast,
  input logic        done,
  input logic        errCap
);

  logic readOpen;

  always_ff @(posedge clk) begin
    if (!rst_n) readOpen <= 1'b0;
    else if (memReqValid) readOpen <= 1'b1;
    else if (memRspValid) readOpen <= 1'b0;
  end

  // R2: a new read only once the previous one has been answered
  assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    memReqValid |-> !readOpen);

  // R2: no read while a pair is being offered
  assert_no_read_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pairValid |-> !memReqValid);

  // R5: an offered pair is held until taken
  assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pairValid && !pairReady) |=>
      (pairValid && $stable(pairAddr) && $stable(pairLen) && $stable(pairLast)));

  // R6: done is a single-cycle pulse following a marked acceptance
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pairValid && pairReady && pairLast));

  // R7: cap error follows an unmarked acceptance and leaves the walker idle
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    errCap |-> ($past(pairValid && pairReady && !pairLast) && !busy));

  // R8: completion and cap error never coincide
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && errCap));

endmodule

bind sgl_walker sgl_walker_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .memReqValid (memReqValid),
  .memRspValid (memRspValid),
  .pairValid   (pairValid),
  .pairReady   (pairReady),
  .pairAddr    (pairAddr),
  .pairLen     (pairLen),
  .pairLast    (pairLast),
  .done        (done),
  .errCap      (errCap)
);

// File: tb/sim_sgl_walker.sv
`timescale 1ns/1ps
module sim_sgl_walker;

  localparam int MAXE = 256;
  localparam int NVEC = 4;
  // base, entries, memory latency, ready mode, seed
  localparam int VEC [0:NVEC-1][0:4] = '{
    '{32'h0000_0100, 1, 1, 0, 3},
    '{32'h0000_0208, 5, 2, 1, 7},
    '{32'hA000_0400, 9, 3, 2, 11},
    '{32'h0000_0600, 3, 1, 2, 5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        busy, memReqValid, memRspValid, pairValid, pairReady;
  logic [31:0] memReqAddr, memRspData;
  logic [30:0] pairAddr;
  logic [27:0] pairLen;
  logic        pairLast, done, errCap;

  always #2.5 clk = ~clk;

  sgl_walker #(.ADDR_W(32), .MAX_ENTRIES(MAXE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .baseAddr(baseAddr), .busy(busy),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .pairValid(pairValid), .pairReady(pairReady), .pairAddr(pairAddr),
    .pairLen(pairLen), .pairLast(pairLast), .done(done), .errCap(errCap)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:2047];
  logic [31:0] reqLog [0:2047];
  logic [30:0] gotAdr [0:1023];
  logic [27:0] gotLen [0:1023];
  logic        gotLast [0:1023];
  int reqN = 0, pairN = 0, doneN = 0, errN = 0, doneAt = 0, errAt = 0;
  int memLat = 1, readyMode = 0, holdBad = 0, zeroSeen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] lenWordOf(int seed, int i, bit last);
    logic [27:0] l;
    l = (i % 4 == 2) ? 28'd0 : 28'(seed * 977 + i * 4099 + 1);
    return {last, (i % 2 == 1) ? 3'b110 : 3'b001, l};
  endfunction

  function automatic logic [31:0] adrWordOf(int seed, int i);
    return {(i % 2 == 0), 31'(seed * 32'h1357 + i * 32'h2468)};
  endfunction

  // memory responder: one answer per request, memLat cycles later
  initial begin
    int wait_c = 0;
    logic [10:0] pend = '0;
    memRspValid = 1'b0;
    memRspData  = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (wait_c > 0) begin
        wait_c--;
        if (wait_c == 0) begin
          memRspValid = 1'b1;
          memRspData  = mem[pend];
        end
      end
      if (rst_n && memReqValid) begin
        if (reqN < 2048) reqLog[reqN] = memReqAddr;
        reqN++;
        pend   = memReqAddr[12:2];
        wait_c = memLat;
      end
    end
  end

  // consumer: drives ready, records accepted pairs and pulses
  initial begin
    int cyc = 0;
    bit held = 0;
    logic [59:0] heldVal = '0;
    pairReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (held && pairValid && ({pairAddr, pairLen, pairLast} != heldVal)) holdBad++;
      if (held && !pairValid) holdBad++;
      case (readyMode)
        0: pairReady = 1'b1;
        1: pairReady = (cyc % 2 == 0);
        default: pairReady = (cyc % 3 == 0);
      endcase
      held = pairValid && !pairReady;
      heldVal = {pairAddr, pairLen, pairLast};
      if (pairValid && pairReady) begin
        if (pairN < 1024) begin
          gotAdr[pairN] = pairAddr;
          gotLen[pairN] = pairLen;
          gotLast[pairN] = pairLast;
        end
        if (pairLen == 0) zeroSeen++;
        pairN++;
      end
      if (done) begin doneN++; doneAt = pairN; end
      if (errCap) begin errN++; errAt = pairN; end
    end
  end

  task automatic runWalk(input logic [31:0] base, input int n, input int lastAt,
                         input int lat, input int mode, input int seed,
                         input int restartAt, input string tag);
    int p0, r0, d0, e0, k, badReq, badLen, badAdr;
    logic [31:0] lw, aw;
    for (int i = 0; i < n; i++) begin
      mem[11'((base + 32'(i * 8)) >> 2)]     = lenWordOf(seed, i, i == lastAt);
      mem[11'((base + 32'(i * 8 + 4)) >> 2)] = adrWordOf(seed, i);
    end
    memLat = lat;
    readyMode = mode;
    @(negedge clk);
    p0 = pairN; r0 = reqN; d0 = doneN; e0 = errN;
    baseAddr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    baseAddr = 32'h0000_1F00;
    k = 0;
    while (doneN == d0 && errN == e0 && k < 8000) begin
      @(negedge clk);
      k++;
      start = (k == restartAt);
    end
    start = 1'b0;
    repeat (6) @(negedge clk);
    chk(k < 8000, "R6", {tag, " walk finished"}, k, 0);
    chk(pairN - p0 == n, "R6", {tag, " pair count"}, pairN - p0, n);
    if (lastAt >= 0) begin
      chk(doneN - d0 == 1 && errN == e0, "R8", {tag, " done only"}, doneN - d0, 1);
      chk(doneAt == p0 + n, "R6", {tag, " done after last pair"}, doneAt, p0 + n);
    end else begin
      chk(errN - e0 == 1 && doneN == d0, "R7", {tag, " cap error only"}, errN - e0, 1);
      chk(errAt == p0 + n, "R7", {tag, " error after final pair"}, errAt, p0 + n);
    end
    chk(reqN - r0 == 2 * n, "R2", {tag, " read count (R10 base kept)"}, reqN - r0, 2 * n);
    badReq = 0; badLen = 0; badAdr = 0;
    for (int i = 0; i < n; i++) begin
      if (reqLog[r0 + 2 * i] != base + 32'(i * 8)) badReq++;
      if (reqLog[r0 + 2 * i + 1] != base + 32'(i * 8 + 4)) badReq++;
      lw = lenWordOf(seed, i, i == lastAt);
      aw = adrWordOf(seed, i);
      if (gotLen[p0 + i] != lw[27:0] || gotLast[p0 + i] != lw[31]) badLen++;
      if (gotAdr[p0 + i] != aw[30:0]) badAdr++;
    end
    chk(badReq == 0, "R2", {tag, " read addresses"}, badReq, 0);
    chk(badLen == 0, "R3", {tag, " length and last fields"}, badLen, 0);
    chk(badAdr == 0, "R4", {tag, " masked address"}, badAdr, 0);
    chk(!busy && !pairValid, "R6", {tag, " idle after walk"}, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    chk(!busy && !memReqValid && !pairValid && !done && !errCap, "R1",
        "reset outputs", {busy, memReqValid, pairValid, done, errCap}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !memReqValid, "R1", "idle after reset release", busy, 0);

    for (int v = 0; v < NVEC; v++)
      runWalk(VEC[v][0], VEC[v][1], VEC[v][1] - 1, VEC[v][2], VEC[v][3], VEC[v][4],
              0, $sformatf("vec%0d", v));

    // R9: zero-length entries from the tables were forwarded
    chk(zeroSeen >= 2, "R9", "zero-length pairs forwarded", zeroSeen, 2);

    // R10: second start mid-walk must not restart or rebase the walk
    runWalk(32'h0000_0700, 6, 5, 2, 1, 13, 7, "R10 restart ignored");

    // R7: list with no terminator hits the cap
    runWalk(32'h0000_0800, MAXE, -1, 1, 0, 17, 0, "R7 cap");
    // R8: terminator exactly on the capped entry
    runWalk(32'h0000_0800, MAXE, MAXE - 1, 1, 1, 19, 0, "R8 last at cap");

    chk(holdBad == 0, "R5", "pair held under backpressure", holdBad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule